// File: doc/BRIEF.md
# Two-Level Prioritized Event Controller

This block gathers level-sensitive peripheral requests and a handful of fixed core events and turns them into one prioritized dispatch with a vector address. It has two stages. The system stage samples each peripheral line into a status bit and applies a system mask. A 4-bit routing field then sends the request to one of nine general-purpose levels (7 to 15). More than one source may share a level. The core stage holds a latch bit per level and a per-level enable. It selects the most urgent eligible level and presents the vector stored for that level in a programmable table.

Acceptance and completion are tracked separately from latching. When the consumer accepts a dispatch, the level's latch bit clears and its pending bit sets in the same step. A return strobe clears only the pending bit. The peripheral status keeps following its source line, so a handler has to silence the source itself. Seven fixed events (levels 0 to 6) bypass the system stage entirely. A wakeup output reports any enabled source whose request is active, whatever the system mask holds.

All configuration goes through a simple single-cycle word-addressed register port. Register writes take effect at the next clock edge. Reads are combinational.

Top module: `evt_two_level_ctrl`

## Requirements
- R1: Status bit i equals `src_req_i[i]` as sampled at the previous clock edge. A return strobe never clears it. Status reads at address 0x02.
- R2: Source i uses the 4-bit field at bits [4*(i%8)+3 : 4*(i%8)] of routing word 0x08+i/8. A field value v routes to level 7+v when v ≤ 8, and to level 15 when v > 8. The reset value of every field is 0 (level 7). Sources that share a level set one latch bit.
- R3: Bit i of the system mask (address 0x00, 1 = enabled, reset 0) gates source i before routing. A masked source never sets a latch bit, but its status bit still follows the line.
- R4: A latch bit (read at 0x04) sets one cycle after the status bit for its level rises. It holds until that level is accepted. `fixed_req_i[k]` sets latch bit k directly, whatever the system mask, routing or wakeup settings hold.
- R5: Bit L of the core enable register (address 0x03, reset 0) gates level L for dispatch. A level that is not enabled stays latched but is not dispatched. Levels 0 to 3 are always enabled.
- R6: Among latched and enabled levels, the lowest level number wins. `irq_level_o` gives that level. `irq_vector_o` gives table entry 0x10+level.
- R7: `irq_valid_o` is high only when the winning level is numerically lower than every level whose pending bit is set.
- R8: A cycle with `irq_ack_i` and `irq_valid_o` both high sets the pending bit of the dispatched level (read at 0x05) and clears its latch bit at the same clock edge.
- R9: A cycle with `irq_ret_i` high clears the lowest-numbered pending bit.
- R10: `wake_o` is high exactly when some source has both its status bit and its wakeup enable bit (address 0x01, reset 0) set. The system mask has no effect on it.
- R11: After reset the following all read 0: masks, enables, status, latch, pending and vector entries. `irq_valid_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NSRC | Level-sensitive peripheral requests |
| fixed_req_i | input | 7 | Fixed core events for levels 0 to 6 |
| irq_ack_i | input | 1 | Accepts the current dispatch |
| irq_ret_i | input | 1 | Return strobe, clears the top pending level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_valid_o | output | 1 | A dispatch is offered |
| irq_level_o | output | 4 | Offered level |
| irq_vector_o | output | VEC_W | Vector address of the offered level |
| wake_o | output | 1 | Wakeup indication |

## Verification
The bench aims at nesting. An already pending level must block dispatch of a less urgent latched level, yet let a more urgent fixed event through. A design that compares against the wrong end of the pending set would either hand out nested dispatches of equal rank or starve preemption. It also checks that status stays set after a return while the source is high. A design that cleared status on return would lose the request.

Routing-field saturation above 8 and sharing of one level by two sources are checked directly. So are masked levels that must remain latched, and the always-enabled levels 0 to 3. Random configurations then compare the latch image, winner and vector against a bench model. Any slip in routing or priority would show up there as a wrong latch bit or wrong winner.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int LVL_N    = 16;
  localparam int LVL_W    = 4;
  localparam int GP_BASE  = 7;
  localparam int GP_N     = LVL_N - GP_BASE;
  localparam int FIX_N    = GP_BASE;
  localparam int NOMASK_N = 4;
  localparam int FLD_W    = 4;
  localparam int DW       = 32;
  localparam int AW       = 6;
  localparam int FLD_PER_W = DW / FLD_W;

  localparam logic [AW-1:0] A_SMASK = 6'h00;
  localparam logic [AW-1:0] A_WAKE  = 6'h01;
  localparam logic [AW-1:0] A_STAT  = 6'h02;
  localparam logic [AW-1:0] A_CEN   = 6'h03;
  localparam logic [AW-1:0] A_LAT   = 6'h04;
  localparam logic [AW-1:0] A_PEND  = 6'h05;
  localparam logic [AW-1:0] A_ROUTE = 6'h08;
  localparam logic [AW-1:0] A_VEC   = 6'h10;

  // routing field to general-purpose slot index (0 = level 7 .. 8 = level 15)
  function automatic logic [LVL_W-1:0] route_slot(input logic [FLD_W-1:0] fld);
    return (fld > FLD_W'(GP_N - 1)) ? LVL_W'(GP_N - 1) : LVL_W'(fld);
  endfunction
endpackage

// File: rtl/evt_lowest_pick.sv
module evt_lowest_pick #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/evt_sys_stage.sv
module evt_sys_stage
  import evt_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSRC-1:0]       src_req_i,
  input  logic [NSRC-1:0]       smask_i,
  input  logic [NSRC-1:0]       wake_en_i,
  input  logic [NSRC*FLD_W-1:0] route_i,
  output logic [NSRC-1:0]       status_o,
  output logic [GP_N-1:0]       gp_req_o,
  output logic                  wake_o
);
  logic [NSRC-1:0] sts_d, sts_q;

  assign sts_d = src_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  always_comb begin
    gp_req_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sts_q[i] && smask_i[i]) gp_req_o[route_slot(route_i[i*FLD_W +: FLD_W])] = 1'b1;
    end
  end

  assign status_o = sts_q;
  assign wake_o   = |(sts_q & wake_en_i);
endmodule

// File: rtl/evt_core_stage.sv
module evt_core_stage
  import evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_N-1:0] set_i,
  input  logic [LVL_N-1:0] en_i,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic [LVL_N-1:0] lat_o,
  output logic [LVL_N-1:0] pend_o,
  output logic             disp_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_N-1:0] lat_q, lat_d, pend_q, pend_d;
  logic             win_any, pend_any, take, lat_en, pend_en;
  logic [LVL_W-1:0] win_lvl, pend_top;

  evt_lowest_pick #(.N(LVL_N), .W(LVL_W)) u_win (
    .vec_i(lat_q & en_i), .any_o(win_any), .idx_o(win_lvl));

  evt_lowest_pick #(.N(LVL_N), .W(LVL_W)) u_top (
    .vec_i(pend_q), .any_o(pend_any), .idx_o(pend_top));

  assign disp_o = win_any && (!pend_any || (win_lvl < pend_top));
  assign take   = ack_i && disp_o;

  always_comb begin
    lat_en = take || (|set_i);
    lat_d  = lat_q;
    if (take) lat_d[win_lvl] = 1'b0;
    lat_d = lat_d | set_i;
  end

  always_comb begin
    pend_en = take || (ret_i && pend_any);
    pend_d  = pend_q;
    if (ret_i && pend_any) pend_d[pend_top] = 1'b0;
    if (take)              pend_d[win_lvl]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      pend_q <= '0;
    end else begin
      if (lat_en)  lat_q  <= lat_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign lat_o  = lat_q;
  assign pend_o = pend_q;
  assign lvl_o  = win_lvl;
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int VEC_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [NSRC-1:0]       status_i,
  input  logic [LVL_N-1:0]      lat_i,
  input  logic [LVL_N-1:0]      pend_i,
  input  logic [LVL_W-1:0]      sel_lvl_i,
  output logic [NSRC-1:0]       smask_o,
  output logic [NSRC-1:0]       wake_en_o,
  output logic [LVL_N-1:0]      cen_o,
  output logic [NSRC*FLD_W-1:0] route_o,
  output logic [VEC_W-1:0]      vec_o
);
  localparam int RWORDS = NSRC / FLD_PER_W;

  logic [NSRC-1:0]  smask_q, wake_q;
  logic [LVL_N-1:0] cen_q;
  logic             smask_we, wake_we, cen_we;
  logic [DW-1:0]    route_q [RWORDS];
  logic [VEC_W-1:0] vec_q   [LVL_N];

  assign smask_we = we_i && (addr_i == A_SMASK);
  assign wake_we  = we_i && (addr_i == A_WAKE);
  assign cen_we   = we_i && (addr_i == A_CEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smask_q <= '0;
      wake_q  <= '0;
      cen_q   <= '0;
    end else begin
      if (smask_we) smask_q <= wdata_i[NSRC-1:0];
      if (wake_we)  wake_q  <= wdata_i[NSRC-1:0];
      if (cen_we)   cen_q   <= wdata_i[LVL_N-1:0];
    end
  end

  for (genvar g = 0; g < RWORDS; g++) begin : g_route
    logic rt_we;
    assign rt_we = we_i && (addr_i == A_ROUTE + AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    route_q[g] <= '0;
      else if (rt_we) route_q[g] <= wdata_i;
    end
    assign route_o[g*DW +: DW] = route_q[g];
  end

  for (genvar g = 0; g < LVL_N; g++) begin : g_vec
    logic vt_we;
    assign vt_we = we_i && (addr_i == A_VEC + AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vec_q[g] <= '0;
      else if (vt_we) vec_q[g] <= wdata_i[VEC_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SMASK: rdata_o = DW'(smask_q);
      A_WAKE:  rdata_o = DW'(wake_q);
      A_STAT:  rdata_o = DW'(status_i);
      A_CEN:   rdata_o = DW'(cen_q);
      A_LAT:   rdata_o = DW'(lat_i);
      A_PEND:  rdata_o = DW'(pend_i);
      default: begin
        for (int g = 0; g < RWORDS; g++)
          if (addr_i == A_ROUTE + AW'(g)) rdata_o = route_q[g];
        for (int g = 0; g < LVL_N; g++)
          if (addr_i == A_VEC + AW'(g)) rdata_o = DW'(vec_q[g]);
      end
    endcase
  end

  assign smask_o   = smask_q;
  assign wake_en_o = wake_q;
  assign cen_o     = cen_q;
  assign vec_o     = vec_q[sel_lvl_i];
endmodule

// File: rtl/evt_two_level_ctrl.sv
module evt_two_level_ctrl
  import evt_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int VEC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSRC-1:0]    src_req_i,
  input  logic [FIX_N-1:0]   fixed_req_i,
  input  logic               irq_ack_i,
  input  logic               irq_ret_i,
  input  logic               reg_we_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               irq_valid_o,
  output logic [LVL_W-1:0]   irq_level_o,
  output logic [VEC_W-1:0]   irq_vector_o,
  output logic               wake_o
);
  logic [NSRC-1:0]       status_w, smask_w, wake_en_w;
  logic [NSRC*FLD_W-1:0] route_w;
  logic [GP_N-1:0]       gp_req_w;
  logic [LVL_N-1:0]      cen_w, core_en_w, set_w, lat_w, pend_w;

  evt_sys_stage #(.NSRC(NSRC)) u_sys (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_req_i(src_req_i),
    .smask_i(smask_w), .wake_en_i(wake_en_w), .route_i(route_w),
    .status_o(status_w), .gp_req_o(gp_req_w), .wake_o(wake_o));

  assign set_w     = {gp_req_w, fixed_req_i};
  assign core_en_w = cen_w | LVL_N'((1 << NOMASK_N) - 1);

  evt_core_stage u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_w), .en_i(core_en_w),
    .ack_i(irq_ack_i), .ret_i(irq_ret_i), .lat_o(lat_w), .pend_o(pend_w),
    .disp_o(irq_valid_o), .lvl_o(irq_level_o));

  evt_regfile #(.NSRC(NSRC), .VEC_W(VEC_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .status_i(status_w),
    .lat_i(lat_w), .pend_i(pend_w), .sel_lvl_i(irq_level_o),
    .smask_o(smask_w), .wake_en_o(wake_en_w), .cen_o(cen_w),
    .route_o(route_w), .vec_o(irq_vector_o));
endmodule

// File: rtl/evt_two_level_chk.sv
module evt_two_level_chk
  import evt_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  src_req_i,
  input logic [FIX_N-1:0] fixed_req_i,
  input logic             irq_ack_i,
  input logic             irq_ret_i,
  input logic             irq_valid_o,
  input logic [LVL_W-1:0] irq_level_o,
  input logic [NSRC-1:0]  status_w,
  input logic [LVL_N-1:0] lat_w,
  input logic [LVL_N-1:0] pend_w,
  input logic [LVL_N-1:0] core_en_w
);
  AST_STATUS_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_w == $past(src_req_i)); // R1

  AST_FIXED_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fixed_req_i != '0) |=> ((lat_w & LVL_N'($past(fixed_req_i))) == LVL_N'($past(fixed_req_i)))); // R4

  AST_DISABLED_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (core_en_w[irq_level_o] && lat_w[irq_level_o])); // R5

  AST_NEST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((pend_w & ((LVL_N'(2) << irq_level_o) - LVL_N'(1))) == '0)); // R7

  AST_ACK_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_valid_o) |=> pend_w[$past(irq_level_o)]); // R8

  AST_RET_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !(irq_ack_i && irq_valid_o) && (pend_w != '0))
      |=> ($countones(pend_w) + 1 == $countones($past(pend_w)))); // R9
endmodule

bind evt_two_level_ctrl evt_two_level_chk #(.NSRC(NSRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_req_i(src_req_i),
  .fixed_req_i(fixed_req_i), .irq_ack_i(irq_ack_i), .irq_ret_i(irq_ret_i),
  .irq_valid_o(irq_valid_o), .irq_level_o(irq_level_o),
  .status_w(status_w), .lat_w(lat_w), .pend_w(pend_w), .core_en_w(core_en_w));

// File: tb/sim_evt_two_level_ctrl.sv
`timescale 1ns/1ps
module sim_evt_two_level_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [6:0]  fix = '0;
  logic        ack = 1'b0, ret = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, vec_o;
  logic        valid, wake;
  logic [3:0]  lvl;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_smask = 0, m_cen = 0, m_wake = 0;
  logic [3:0]  m_route [32];
  logic [31:0] m_vec [16];

  always #10 clk = ~clk;

  evt_two_level_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src), .fixed_req_i(fix),
    .irq_ack_i(ack), .irq_ret_i(ret), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_valid_o(valid),
    .irq_level_o(lvl), .irq_vector_o(vec_o), .wake_o(wake));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_ack(); @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0; endtask
  task automatic pulse_ret(); @(negedge clk); ret = 1'b1; @(negedge clk); ret = 1'b0; endtask
  task automatic pulse_fix(input int k); @(negedge clk); fix[k] = 1'b1; @(negedge clk); fix = '0; endtask
  task automatic settle(); repeat (3) @(negedge clk); #1; endtask

  task automatic set_cen(input logic [31:0] v); m_cen = v; wr(6'h03, v); endtask
  task automatic set_smask(input logic [31:0] v); m_smask = v; wr(6'h00, v); endtask
  task automatic set_route(input int w, input logic [31:0] v);
    for (int k = 0; k < 8; k++) m_route[w*8+k] = v[k*4 +: 4];
    wr(6'h08 + 6'(w), v);
  endtask

  function automatic logic [15:0] exp_lat(input logic [31:0] s);
    logic [15:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (s[i] && m_smask[i]) r[7 + ((m_route[i] > 4'd8) ? 8 : int'(m_route[i]))] = 1'b1;
    return r;
  endfunction

  function automatic int exp_win(input logic [15:0] l);
    for (int i = 0; i < 16; i++) if (l[i]) return i;
    return -1;
  endfunction

  task automatic drain();
    @(negedge clk); src = '0; fix = '0;
    set_cen(32'hFFFF);
    settle();
    repeat (16) pulse_ret();
    repeat (20) begin
      #1;
      if (valid) begin pulse_ack(); pulse_ret(); end
    end
  endtask

  logic [31:0] d;

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) m_route[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    #1;
    chk("R11 valid", 32'(valid), 0);
    chk("R11 wake", 32'(wake), 0);
    rd(6'h00, d); chk("R11 smask", d, 0);
    rd(6'h03, d); chk("R11 cen", d, 0);
    rd(6'h04, d); chk("R11 latch", d, 0);
    rd(6'h05, d); chk("R11 pend", d, 0);
    rd(6'h15, d); chk("R11 vector", d, 0);

    for (int i = 0; i < 16; i++) begin
      m_vec[i] = $urandom;
      wr(6'h10 + 6'(i), m_vec[i]);
    end
    set_cen(32'hFFFF);
    set_smask(32'h1);

    // R4 fixed event bypasses system stage; R6 vector lookup
    pulse_fix(2); #1;
    chk("R4 fixed valid", 32'(valid), 1);
    chk("R6 fixed level", 32'(lvl), 2);
    chk("R6 fixed vector", vec_o, m_vec[2]);
    // R8 handoff
    pulse_ack();
    rd(6'h05, d); chk("R8 pend", d, 32'h4);
    rd(6'h04, d); chk("R8 latch cleared", d, 0);
    // R7 blocked by pending level 2
    @(negedge clk); src[0] = 1'b1;
    settle();
    rd(6'h04, d); chk("R7 latch7", d, 32'h80);
    chk("R7 blocked", 32'(valid), 0);
    pulse_fix(1); #1;
    chk("R7 preempt valid", 32'(valid), 1);
    chk("R7 preempt level", 32'(lvl), 1);
    pulse_ack();
    rd(6'h05, d); chk("R8 nested pend", d, 32'h6);
    pulse_ret();
    rd(6'h05, d); chk("R9 ret top", d, 32'h4);
    #1 chk("R7 still blocked", 32'(valid), 0);
    pulse_ret();
    rd(6'h05, d); chk("R9 ret second", d, 0);
    #1 chk("R7 released level", 32'(lvl), 7);
    chk("R6 vector7", vec_o, m_vec[7]);
    pulse_ack(); pulse_ret();
    rd(6'h02, d); chk("R1 status kept after ret", d, 32'h1);
    @(negedge clk); src[0] = 1'b0;
    @(negedge clk); addr = 6'h02; #1 chk("R1 status drops", rdata, 0);

    // R5 core enable
    drain();
    set_cen(32'h0);
    @(negedge clk); src[0] = 1'b1;
    settle();
    rd(6'h04, d); chk("R5 held latched", d & 32'h80, 32'h80);
    #1 chk("R5 not dispatched", 32'(valid), 0);
    pulse_fix(0); #1;
    chk("R5 level0 always on", 32'(lvl), 0);
    chk("R5 level0 valid", 32'(valid), 1);
    pulse_ack(); pulse_ret();
    set_cen(32'h80); #1;
    chk("R5 enabled level7", 32'(lvl), 7);
    chk("R5 enabled valid", 32'(valid), 1);

    // R3 system mask
    drain();
    set_smask(32'h0);
    @(negedge clk); src[0] = 1'b1;
    settle();
    rd(6'h02, d); chk("R3 status still follows", d, 32'h1);
    rd(6'h04, d); chk("R3 masked no latch", d, 0);

    // R2 routing and saturation, shared level
    drain();
    set_smask(32'h3);
    set_route(0, 32'h0000_009F);
    @(negedge clk); src = 32'h3;
    settle();
    rd(6'h04, d); chk("R2 fields 15 and 9 -> level15", d, 32'h8000);
    drain();
    set_route(0, 32'h0000_0038);
    @(negedge clk); src = 32'h3;
    settle();
    rd(6'h04, d); chk("R2 fields 8 and 3", d, 32'h8400);
    chk("R6 lowest of two", 32'(lvl), 10);
    drain();
    set_route(0, 32'h0000_0022);
    @(negedge clk); src = 32'h3;
    settle();
    rd(6'h04, d); chk("R2 shared level", d, 32'h200);
    pulse_ack();
    rd(6'h05, d); chk("R8 shared one pend", d, 32'h200);

    // R10 wakeup ignores system mask
    drain();
    set_smask(32'h0);
    m_wake = 32'h2; wr(6'h01, m_wake);
    @(negedge clk); src = 32'h2;
    @(negedge clk); #1 chk("R10 wake on", 32'(wake), 1);
    @(negedge clk); src = '0;
    @(negedge clk); #1 chk("R10 wake off", 32'(wake), 0);

    // random configurations: R2 R3 R5 R6 R10
    for (int it = 0; it < 40; it++) begin
      logic [15:0] el, elig;
      int w;
      drain();
      set_smask($urandom);
      for (int k = 0; k < 4; k++) set_route(k, $urandom);
      m_wake = $urandom; wr(6'h01, m_wake);
      set_cen($urandom & 32'hFFFF);
      @(negedge clk); src = $urandom & $urandom;
      settle();
      el = exp_lat(src);
      elig = el & (m_cen[15:0] | 16'h000F);
      w = exp_win(elig);
      chk("R10 rand wake", 32'(wake), 32'(|(src & m_wake)));
      chk("R5 rand valid", 32'(valid), 32'(w >= 0));
      if (w >= 0) begin
        chk("R6 rand level", 32'(lvl), w);
        chk("R6 rand vector", vec_o, m_vec[w]);
      end
      rd(6'h04, d); chk("R2 rand latch", d, 32'(el));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule